// File: doc/BRIEF.md
# Hybrid Circuit/Packet Output Link Arbiter

This block is the logic behind one output port of a mesh router that carries two traffic classes over the same link. A configuration store holds a few circuit planes. Each plane records whether it is in use and which input port it connects to this output. A narrow setup message writes a plane. The message carries a plane number, a destination node and the input port it arrived on. The block routes the destination in X-then-Y order from its own node position and keeps only the setups that leave through this output. A flit tagged for a configured circuit crosses in one registered stage, with no buffering and no allocation.

Packet-switched flits arrive from the multi-stage pipeline through a request/grant pair, which stands in for the virtual channel allocator. A packet flit takes the link in any cycle that carries no circuit flit. Circuits are built while the first data transfer is in flight, and no acknowledgement is awaited. A setup that finds its plane held by a different input first clears the old mapping. It then travels a short buffered pipeline, the packet path, before the new mapping is written. A circuit-tagged flit that finds no matching mapping leaves through a demotion strobe back into the packet input buffer of its input port.

Top module: `hcs_out_link`

## Requirements
- R1: For the cycle after synchronous reset, every plane is unused, `link_valid` is 0 and `demote` is 0.
- R2: A setup is claimed only when its destination routes out of this port in X-then-Y order. The destination's low half is the X coordinate and its high half is the Y coordinate. East means a larger X. A setup that is not claimed leaves the planes unchanged.
- R3: A claimed setup on an unused plane takes effect for circuit flits presented from the next cycle on. A circuit flit that is presented in the same cycle as its setup is demoted. A flit on a matching plane and input appears on the link one cycle later with `link_circ`=1.
- R4: When a matching circuit flit and a packet request fall in the same cycle, the circuit flit takes the link and `ps_gnt` is 0 in that cycle.
- R5: In a cycle with no matching circuit flit, a packet request is granted in the same cycle. Its data appears on the link one cycle later with `link_circ`=0.
- R6: A circuit-tagged flit is demoted one cycle after it is presented, and it does not appear on the link, in two cases: its plane is unused, or its plane maps a different input. `demote` bit i belongs to input i. A demoted flit does not block a packet grant.
- R7: When several inputs present matching circuit flits in one cycle, the lowest-numbered input wins the link and the others are demoted.
- R8: A claimed setup on a plane held by another input clears that plane at once. The new mapping is written RECONF_STAGES cycles later. Flits on that plane are demoted until then, whichever input presents them.
- R9: A claimed setup on a plane already held by the same input leaves the circuit usable without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | Setup message present |
| setup_plane | input | PLANE_W | Circuit plane of the setup |
| setup_dest | input | DEST_W | Destination node of the setup |
| setup_port | input | PORT_W | Input port the setup arrived on |
| cin_valid | input | NUM_PORTS | Circuit-tagged flit present, per input |
| cin_plane | input | NUM_PORTS*PLANE_W | Plane tag per input |
| cin_data | input | NUM_PORTS*FLIT_W | Circuit flit payload per input |
| ps_req | input | 1 | Packet flit requests the link |
| ps_data | input | FLIT_W | Packet flit payload |
| ps_gnt | output | 1 | Packet flit granted this cycle |
| link_valid | output | 1 | Registered link flit valid |
| link_circ | output | 1 | Registered link flit is circuit-switched |
| link_data | output | FLIT_W | Registered link payload |
| demote | output | NUM_PORTS | Registered per-input demotion strobe |

## Verification
The bench puts a matching circuit flit and a packet request in the same cycle. It expects the circuit payload on the link and `ps_gnt` low, and in the next cycle it expects the packet to win the idle link. It also puts two matching circuit flits on different planes in one cycle. It expects the lower input on the link and the other input's demote bit set. Each cycle's expected link word and demote mask come from a scoreboard queue that the driver fills.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  typedef enum logic [2:0] {
    DIR_EJECT = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;
endpackage

// File: rtl/hcs_setup_decode.sv
module hcs_setup_decode #(
  parameter int DEST_W  = 4,
  parameter int NODE_ID = 5,
  parameter hcs_pkg::dir_e OUT_DIR = hcs_pkg::DIR_EAST,
  parameter int PLANE_W = 2,
  parameter int PORT_W  = 3
) (
  input  logic               setup_valid,
  input  logic [PLANE_W-1:0] setup_plane,
  input  logic [DEST_W-1:0]  setup_dest,
  input  logic [PORT_W-1:0]  setup_port,
  output logic               claim,
  output logic [PLANE_W-1:0] claim_plane,
  output logic [PORT_W-1:0]  claim_port
);
  localparam int XW = DEST_W / 2;
  localparam int YW = DEST_W - XW;
  localparam int MX = NODE_ID % (1 << XW);
  localparam int MY = NODE_ID / (1 << XW);

  logic [XW-1:0] dx;
  logic [YW-1:0] dy;
  hcs_pkg::dir_e route;

  assign dx = setup_dest[XW-1:0];
  assign dy = setup_dest[DEST_W-1:XW];

  always_comb begin
    if (dx > XW'(MX))      route = hcs_pkg::DIR_EAST;
    else if (dx < XW'(MX)) route = hcs_pkg::DIR_WEST;
    else if (dy > YW'(MY)) route = hcs_pkg::DIR_SOUTH;
    else if (dy < YW'(MY)) route = hcs_pkg::DIR_NORTH;
    else                   route = hcs_pkg::DIR_EJECT;
  end

  assign claim       = setup_valid && (route == OUT_DIR);
  assign claim_plane = setup_plane;
  assign claim_port  = setup_port;
endmodule

// File: rtl/hcs_plane_store.sv
module hcs_plane_store #(
  parameter int NUM_PLANES    = 4,
  parameter int PLANE_W       = 2,
  parameter int PORT_W        = 3,
  parameter int RECONF_STAGES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         claim,
  input  logic [PLANE_W-1:0]           claim_plane,
  input  logic [PORT_W-1:0]            claim_port,
  output logic [NUM_PLANES-1:0]        plane_valid,
  output logic [NUM_PLANES*PORT_W-1:0] plane_port
);
  logic              cur_valid;
  logic [PORT_W-1:0] cur_port;
  logic              reconf;

  logic [RECONF_STAGES-1:0] pipe_v;
  logic [PLANE_W-1:0]       pipe_plane [RECONF_STAGES];
  logic [PORT_W-1:0]        pipe_port  [RECONF_STAGES];

  assign cur_valid = plane_valid[claim_plane];
  assign cur_port  = plane_port[claim_plane*PORT_W +: PORT_W];
  assign reconf    = claim && cur_valid && (cur_port != claim_port);

  // Reconfiguration messages ride a buffered pipeline, like packet flits.
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_v <= '0;
      for (int s = 0; s < RECONF_STAGES; s++) begin
        pipe_plane[s] <= '0;
        pipe_port[s]  <= '0;
      end
    end else begin
      pipe_v[0]     <= reconf;
      pipe_plane[0] <= claim_plane;
      pipe_port[0]  <= claim_port;
      for (int s = 1; s < RECONF_STAGES; s++) begin
        pipe_v[s]     <= pipe_v[s-1];
        pipe_plane[s] <= pipe_plane[s-1];
        pipe_port[s]  <= pipe_port[s-1];
      end
    end
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic hit, wr_now, clr, pexit;
    assign hit    = claim && (claim_plane == PLANE_W'(p));
    assign wr_now = hit && !plane_valid[p];
    assign clr    = hit && plane_valid[p] && (plane_port[p*PORT_W +: PORT_W] != claim_port);
    assign pexit  = pipe_v[RECONF_STAGES-1] && (pipe_plane[RECONF_STAGES-1] == PLANE_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        plane_valid[p]                <= 1'b0;
        plane_port[p*PORT_W +: PORT_W] <= '0;
      end else if (clr) begin
        plane_valid[p] <= 1'b0;
      end else if (wr_now) begin
        plane_valid[p]                <= 1'b1;
        plane_port[p*PORT_W +: PORT_W] <= claim_port;
      end else if (pexit) begin
        plane_valid[p]                <= 1'b1;
        plane_port[p*PORT_W +: PORT_W] <= pipe_port[RECONF_STAGES-1];
      end
    end
  end
endmodule

// File: rtl/hcs_link_mux.sv
module hcs_link_mux #(
  parameter int NUM_PORTS  = 5,
  parameter int NUM_PLANES = 4,
  parameter int PLANE_W    = 2,
  parameter int PORT_W     = 3,
  parameter int FLIT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PLANES-1:0]        plane_valid,
  input  logic [NUM_PLANES*PORT_W-1:0] plane_port,
  input  logic [NUM_PORTS-1:0]         cin_valid,
  input  logic [NUM_PORTS*PLANE_W-1:0] cin_plane,
  input  logic [NUM_PORTS*FLIT_W-1:0]  cin_data,
  input  logic                         ps_req,
  input  logic [FLIT_W-1:0]            ps_data,
  output logic                         ps_gnt,
  output logic                         link_valid,
  output logic                         link_circ,
  output logic [FLIT_W-1:0]            link_data,
  output logic [NUM_PORTS-1:0]         demote
);
  logic [NUM_PORTS-1:0] match;
  logic [NUM_PORTS-1:0] win;
  logic                 any_win;
  logic [FLIT_W-1:0]    win_data;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_match
    logic [PLANE_W-1:0] pl;
    assign pl       = cin_plane[i*PLANE_W +: PLANE_W];
    assign match[i] = cin_valid[i] && plane_valid[pl] &&
                      (plane_port[pl*PORT_W +: PORT_W] == PORT_W'(i));
  end

  always_comb begin
    win      = '0;
    any_win  = 1'b0;
    win_data = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (match[i] && !any_win) begin
        win[i]   = 1'b1;
        any_win  = 1'b1;
        win_data = cin_data[i*FLIT_W +: FLIT_W];
      end
    end
  end

  assign ps_gnt = ps_req && !any_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_circ  <= 1'b0;
      link_data  <= '0;
      demote     <= '0;
    end else begin
      link_valid <= any_win || ps_req;
      link_circ  <= any_win;
      link_data  <= any_win ? win_data : (ps_req ? ps_data : '0);
      demote     <= cin_valid & ~win;
    end
  end
endmodule

// File: rtl/hcs_out_link.sv
module hcs_out_link #(
  parameter int NUM_PORTS     = 5,
  parameter int NUM_PLANES    = 4,
  parameter int FLIT_W        = 16,
  parameter int DEST_W        = 4,
  parameter int RECONF_STAGES = 3,
  parameter int NODE_ID       = 5,
  parameter hcs_pkg::dir_e OUT_DIR = hcs_pkg::DIR_EAST,
  localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
  localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         setup_valid,
  input  logic [PLANE_W-1:0]           setup_plane,
  input  logic [DEST_W-1:0]            setup_dest,
  input  logic [PORT_W-1:0]            setup_port,
  input  logic [NUM_PORTS-1:0]         cin_valid,
  input  logic [NUM_PORTS*PLANE_W-1:0] cin_plane,
  input  logic [NUM_PORTS*FLIT_W-1:0]  cin_data,
  input  logic                         ps_req,
  input  logic [FLIT_W-1:0]            ps_data,
  output logic                         ps_gnt,
  output logic                         link_valid,
  output logic                         link_circ,
  output logic [FLIT_W-1:0]            link_data,
  output logic [NUM_PORTS-1:0]         demote
);
  logic                         claim;
  logic [PLANE_W-1:0]           claim_plane;
  logic [PORT_W-1:0]            claim_port;
  logic [NUM_PLANES-1:0]        plane_valid;
  logic [NUM_PLANES*PORT_W-1:0] plane_port;

  hcs_setup_decode #(
    .DEST_W(DEST_W), .NODE_ID(NODE_ID), .OUT_DIR(OUT_DIR),
    .PLANE_W(PLANE_W), .PORT_W(PORT_W)
  ) u_dec (
    .setup_valid(setup_valid), .setup_plane(setup_plane),
    .setup_dest(setup_dest), .setup_port(setup_port),
    .claim(claim), .claim_plane(claim_plane), .claim_port(claim_port)
  );

  hcs_plane_store #(
    .NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W), .PORT_W(PORT_W),
    .RECONF_STAGES(RECONF_STAGES)
  ) u_store (
    .clk(clk), .rst(rst), .claim(claim), .claim_plane(claim_plane),
    .claim_port(claim_port), .plane_valid(plane_valid), .plane_port(plane_port)
  );

  hcs_link_mux #(
    .NUM_PORTS(NUM_PORTS), .NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W),
    .PORT_W(PORT_W), .FLIT_W(FLIT_W)
  ) u_mux (
    .clk(clk), .rst(rst), .plane_valid(plane_valid), .plane_port(plane_port),
    .cin_valid(cin_valid), .cin_plane(cin_plane), .cin_data(cin_data),
    .ps_req(ps_req), .ps_data(ps_data), .ps_gnt(ps_gnt),
    .link_valid(link_valid), .link_circ(link_circ), .link_data(link_data),
    .demote(demote)
  );
endmodule

// File: rtl/hcs_out_link_chk.sv
module hcs_out_link_chk #(
  parameter int NUM_PORTS  = 5,
  parameter int NUM_PLANES = 4,
  parameter int FLIT_W     = 16,
  parameter int PLANE_W    = 2,
  parameter int PORT_W     = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_PORTS-1:0]         cin_valid,
  input logic                         ps_req,
  input logic [FLIT_W-1:0]            ps_data,
  input logic                         ps_gnt,
  input logic                         link_valid,
  input logic                         link_circ,
  input logic [FLIT_W-1:0]            link_data,
  input logic [NUM_PORTS-1:0]         demote,
  input logic                         claim,
  input logic [PLANE_W-1:0]           claim_plane,
  input logic [PORT_W-1:0]            claim_port,
  input logic [NUM_PLANES-1:0]        plane_valid,
  input logic [NUM_PLANES*PORT_W-1:0] plane_port
);
  logic [PORT_W-1:0] held_port;
  assign held_port = plane_port[claim_plane*PORT_W +: PORT_W];

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!link_valid && demote == '0));

  a_r5_grant_carries_packet: assert property (@(posedge clk) disable iff (rst)
    ps_gnt |=> (link_valid && !link_circ && link_data == $past(ps_data)));

  a_r4_circuit_blocks_packet: assert property (@(posedge clk) disable iff (rst)
    (ps_req && !ps_gnt) |=> (link_valid && link_circ));

  a_r6_demote_only_presented: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((demote & ~$past(cin_valid)) == '0));

  a_r7_flit_conservation: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(demote) + (link_circ ? 1 : 0) == $countones($past(cin_valid))));

  a_r8_reconf_clears: assert property (@(posedge clk) disable iff (rst)
    (claim && plane_valid[claim_plane] && held_port != claim_port)
      |=> !plane_valid[$past(claim_plane)]);

  a_r9_same_port_kept: assert property (@(posedge clk) disable iff (rst)
    (claim && plane_valid[claim_plane] && held_port == claim_port)
      |=> plane_valid[$past(claim_plane)]);
endmodule

bind hcs_out_link hcs_out_link_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_PLANES(NUM_PLANES), .FLIT_W(FLIT_W),
  .PLANE_W(PLANE_W), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .cin_valid(cin_valid), .ps_req(ps_req),
  .ps_data(ps_data), .ps_gnt(ps_gnt), .link_valid(link_valid),
  .link_circ(link_circ), .link_data(link_data), .demote(demote),
  .claim(claim), .claim_plane(claim_plane), .claim_port(claim_port),
  .plane_valid(plane_valid), .plane_port(plane_port)
);

// File: tb/hcs_out_link_bench.sv
`timescale 1ns/100ps
module hcs_out_link_bench;
  localparam int NP = 5;
  localparam int NPL = 4;
  localparam int FW = 16;
  localparam int RS = 3;
  localparam int PLW = 2;
  localparam int PTW = 3;

  typedef struct {
    logic          lv;
    logic          lc;
    logic [FW-1:0] ld;
    logic [NP-1:0] dm;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic setup_valid = 1'b0;
  logic [PLW-1:0] setup_plane = '0;
  logic [3:0] setup_dest = '0;
  logic [PTW-1:0] setup_port = '0;
  logic [NP-1:0] cin_valid = '0;
  logic [NP*PLW-1:0] cin_plane = '0;
  logic [NP*FW-1:0] cin_data = '0;
  logic ps_req = 1'b0;
  logic [FW-1:0] ps_data = '0;
  logic ps_gnt, link_valid, link_circ;
  logic [FW-1:0] link_data;
  logic [NP-1:0] demote;

  // staged inputs for the next step
  logic s_sv; logic [PLW-1:0] s_spl; logic [3:0] s_sd; logic [PTW-1:0] s_sp;
  logic [NP-1:0] s_cv; logic [NP*PLW-1:0] s_cp; logic [NP*FW-1:0] s_cd;
  logic s_pr; logic [FW-1:0] s_pd;

  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hcs_out_link #(.NUM_PORTS(NP), .NUM_PLANES(NPL), .FLIT_W(FW), .DEST_W(4),
                 .RECONF_STAGES(RS), .NODE_ID(5), .OUT_DIR(hcs_pkg::DIR_EAST))
  u_hcs_out_link (
    .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_plane(setup_plane),
    .setup_dest(setup_dest), .setup_port(setup_port), .cin_valid(cin_valid),
    .cin_plane(cin_plane), .cin_data(cin_data), .ps_req(ps_req), .ps_data(ps_data),
    .ps_gnt(ps_gnt), .link_valid(link_valid), .link_circ(link_circ),
    .link_data(link_data), .demote(demote)
  );

  task automatic clear_stage();
    s_sv = 0; s_spl = '0; s_sd = '0; s_sp = '0;
    s_cv = '0; s_cp = '0; s_cd = '0; s_pr = 0; s_pd = '0;
  endtask

  task automatic put_setup(input int port, input int plane, input int dest);
    s_sv = 1; s_spl = PLW'(plane); s_sd = 4'(dest); s_sp = PTW'(port);
  endtask

  task automatic put_circ(input int port, input int plane, input logic [FW-1:0] d);
    s_cv[port] = 1'b1;
    s_cp[port*PLW +: PLW] = PLW'(plane);
    s_cd[port*FW +: FW] = d;
  endtask

  task automatic put_ps(input logic [FW-1:0] d);
    s_pr = 1; s_pd = d;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply staged inputs, check grant, push expected link result
  task automatic step(input logic lv, input logic lc, input logic [FW-1:0] ld,
                      input logic [NP-1:0] dm, input logic gnt, input string tag);
    exp_t e;
    @(negedge clk);
    setup_valid = s_sv; setup_plane = s_spl; setup_dest = s_sd; setup_port = s_sp;
    cin_valid = s_cv; cin_plane = s_cp; cin_data = s_cd; ps_req = s_pr; ps_data = s_pd;
    e.lv = lv; e.lc = lc; e.ld = ld; e.dm = dm; e.tag = tag;
    q.push_back(e);
    #0.5;
    check({tag, " ps_gnt"}, 32'(ps_gnt), 32'(gnt));
    clear_stage();
  endtask

  // monitor: compare registered outputs one cycle after each step
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " link_valid"}, 32'(link_valid), 32'(e.lv));
        check({e.tag, " demote"}, 32'(demote), 32'(e.dm));
        if (e.lv) begin
          check({e.tag, " link_circ"}, 32'(link_circ), 32'(e.lc));
          check({e.tag, " link_data"}, 32'(link_data), 32'(e.ld));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear_stage();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: outputs quiet right after reset
    check("R1 link_valid after reset", 32'(link_valid), 0);
    check("R1 demote after reset", 32'(demote), 0);
    // R1: all planes unused -> circuit flit on plane 1 from input 0 is demoted
    put_circ(0, 1, 16'h1111);
    step(0, 0, 0, 5'b00001, 0, "R1 plane unused");

    // R5: packet alone is granted and carried
    put_ps(16'hA001);
    step(1, 0, 16'hA001, 0, 1, "R5 packet steal");
    // R6: unused plane -> demote, not on link
    put_circ(1, 0, 16'hBEEF);
    step(0, 0, 0, 5'b00010, 0, "R6 unused plane");
    // R2: setup to dest 4 routes west, not claimed
    put_setup(1, 0, 4);
    step(0, 0, 0, 0, 0, "R2 setup west");
    put_circ(1, 0, 16'hC000);
    step(0, 0, 0, 5'b00010, 0, "R2 ignored setup");
    // R2: dest 9 routes south, not claimed
    put_setup(1, 0, 9);
    step(0, 0, 0, 0, 0, "R2 setup south");
    put_circ(1, 0, 16'hC001);
    step(0, 0, 0, 5'b00010, 0, "R2 ignored south");
    // R3: setup east (dest 6) with flit in same cycle -> flit demoted
    put_setup(1, 0, 6);
    put_circ(1, 0, 16'hC010);
    step(0, 0, 0, 5'b00010, 0, "R3 same cycle as setup");
    put_circ(1, 0, 16'hC111);
    step(1, 1, 16'hC111, 0, 0, "R3 circuit forward");
    // R4: circuit and packet together
    put_circ(1, 0, 16'hC222);
    put_ps(16'hA002);
    step(1, 1, 16'hC222, 0, 0, "R4 circuit wins");
    put_ps(16'hA002);
    step(1, 0, 16'hA002, 0, 1, "R5 packet after circuit");
    // R7: second circuit on plane 2 for input 3
    put_setup(3, 2, 7);
    step(0, 0, 0, 0, 0, "R7 setup plane2");
    put_circ(1, 0, 16'hD001);
    put_circ(3, 2, 16'hD003);
    step(1, 1, 16'hD001, 5'b01000, 0, "R7 lowest input wins");
    put_circ(3, 2, 16'hD033);
    step(1, 1, 16'hD033, 0, 0, "R7 input3 alone");
    // R6: plane 0 mapped to input 1, presented by input 2; demoted flit does not block packet
    put_circ(2, 0, 16'hE002);
    put_ps(16'hA003);
    step(1, 0, 16'hA003, 5'b00100, 1, "R6 wrong input");
    // R9: same-input setup keeps the circuit
    put_setup(1, 0, 14);
    step(0, 0, 0, 0, 0, "R9 repeat setup");
    put_circ(1, 0, 16'hF001);
    step(1, 1, 16'hF001, 0, 0, "R9 no gap");
    // R8: reconfigure plane 0 to input 4
    put_setup(4, 0, 6);
    step(0, 0, 0, 0, 0, "R8 reconf setup");
    put_circ(1, 0, 16'hF111);
    step(0, 0, 0, 5'b00010, 0, "R8 old mapping cleared");
    for (int k = 0; k < RS - 1; k++) begin
      put_circ(4, 0, 16'hF440);
      step(0, 0, 0, 5'b10000, 0, "R8 pending write");
    end
    put_circ(4, 0, 16'hF444);
    step(1, 1, 16'hF444, 0, 0, "R8 new mapping");
    // idle link
    step(0, 0, 0, 0, 0, "R5 idle");
    step(0, 0, 0, 0, 0, "R5 idle2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule